// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a SPI master that works through a queue of up to sixteen word transfers with no processor action between them. Software loads three tables over a simple word-wide register bus: the per-entry command table, the transmit words, and a run-control register that gives the last entry of the run and whether the run repeats. Software then writes the start register. The sequencer takes each entry in turn and runs it through the shift engine. The shift engine produces SCLK from a programmable divider, shifts the transmit word out on MOSI with the MSB first, and shifts MISO into a receive table at the same index.

Each command entry gives the word length (8 bits by default, or the programmed length), a chip-select mask, and a hold bit. The hold bit keeps the select asserted into the next entry, so a device can receive one frame built from several words. When the last entry of a run finishes, a sticky done flag is set. Software clears the flag by writing 1 to it, and a new run cannot start while the flag is set. To read from a device, software sends zero words so that MOSI stays low while the clocks run.

Top module: `qspi_master`

## Requirements
- R1: After reset, every `cs_n` bit is high, `sclk` and `mosi` are low, and the status register (address 0x32) reads 0: done flag in bit 0, busy in bit 1.
- R2: Transfers use SPI mode 0 with the MSB first. SCLK idles low. The first bit is on MOSI a half period before the first rising edge. MOSI changes only after falling edges. MISO is sampled on rising edges, and the received word sits in the low bits of receive entry n (address 0x20+n).
- R3: Command entry n (address 0x00+n) with bit 6 set runs the length in control bits [11:8], where 0 means 16. With bit 6 clear it runs 8 bits. The number of SCLK pulses equals that length.
- R4: Each SCLK high and low phase lasts max(D,1) system clocks, where D is control bits [7:0] (address 0x30). The SCLK period is therefore at least two clocks.
- R5: While entry n runs, `cs_n` is the inverse of command bits [3:0]. When command bit 7 is set, the select stays asserted straight into entry n+1. When bit 7 is clear, all selects go high for at least one half period before the next entry.
- R6: A run covers entries 0 up to the last index in run-control bits [3:0] (address 0x31). Transmit word n (address 0x10+n, low bits sent) is paired with command n. A zero transmit word keeps MOSI low for the whole word.
- R7: Status bit 0 is set when the last entry of a run ends, and the select is released at that point whatever its hold bit says. Writing 1 to status bit 0 clears the flag. Writing 0 there leaves it unchanged.
- R8: A write with bit 0 set to the start register (address 0x33) begins a run only while the controller is idle and the done flag is clear. Otherwise the write is ignored.
- R9: With run-control bit 8 set, the run goes back to entry 0 after the last entry and sets the done flag on every pass. It stops at the end of the first pass that finishes after bit 8 has been cleared.
- R10: Status bit 1 reads 1 from the cycle after an accepted start until the run has stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address: bits [5:4] select the region, bits [3:0] the index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that every command entry in a run has a non-zero select mask, and that the control register is not rewritten while a run is active. The SCLK-spacing and select-during-clock properties depend on both. Every test programs its divider, length and tables while the controller is idle, and uses only one-hot masks. The one register that does change during a run is the run-control register in the repeat test, and it holds no timing value. A loopback slave returns the inverse of MOSI, so each receive word is known from its transmit word.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    localparam int unsigned QDEPTH  = 16;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned CS_W    = 4;
    localparam int unsigned DIV_W   = 8;
    localparam int unsigned DEF_LEN = 8;
    localparam int unsigned PTR_W   = $clog2(QDEPTH);
    localparam int unsigned LEN_W   = $clog2(WORD_W);
    localparam int unsigned BITS_W  = $clog2(WORD_W + 1);
    localparam int unsigned ADDR_W  = PTR_W + 2;

    typedef struct packed {
        logic            hold;
        logic            use_len;
        logic [CS_W-1:0] sel;
    } cmd_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_RUN, SQ_GAP} seq_e;

    function automatic logic [BITS_W-1:0] word_bits(input cmd_t c, input logic [LEN_W-1:0] len);
        if (!c.use_len)      return BITS_W'(DEF_LEN);
        else if (len == '0)  return BITS_W'(WORD_W);
        else                 return BITS_W'(len);
    endfunction

    function automatic logic [DIV_W-1:0] half_of(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction
endpackage

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + DIV_W'(1);
    end

    // R4: back-to-back ticks only when a half period is one clock
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && half > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
    parameter int unsigned W  = 16,
    parameter int unsigned BW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  tx_word,
    input  logic [BW-1:0] nbits,
    input  logic          tick,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          active,
    output logic          word_done,
    output logic [W-1:0]  rx_word
);
    localparam logic [BW-1:0] WB = BW'(W);

    logic [W-1:0]  sh;
    logic [W-1:0]  rxs;
    logic [BW-1:0] left;

    assign mosi    = active & sh[W-1];
    assign rx_word = rxs;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            sh        <= '0;
            rxs       <= '0;
            left      <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= active && tick && sclk && (left == BW'(1));
            if (start && !active) begin
                active <= 1'b1;
                sclk   <= 1'b0;
                sh     <= tx_word << (WB - nbits);
                rxs    <= '0;
                left   <= nbits;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rxs  <= {rxs[W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    sh   <= sh << 1;
                    left <= left - BW'(1);
                    if (left == BW'(1)) active <= 1'b0;
                end
            end
        end
    end

    // R2: the sequencer only launches a word into an idle engine
    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);
    // R2: data holds while SCLK is high (mode 0)
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (active && sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_we,
    input  logic [qspi_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [qspi_pkg::WORD_W-1:0]   bus_wdata,
    output logic [qspi_pkg::WORD_W-1:0]   bus_rdata,
    output logic                          sclk,
    output logic                          mosi,
    input  logic                          miso,
    output logic [qspi_pkg::CS_W-1:0]     cs_n
);
    cmd_t              cmd_q [QDEPTH];
    logic [WORD_W-1:0] tx_q  [QDEPTH];
    logic [WORD_W-1:0] rx_q  [QDEPTH];
    ctrl_t             ctrl_q;
    logic [PTR_W-1:0]  end_ptr, ptr;
    logic              wrap_en, done_q;
    logic [CS_W-1:0]   cs_q;
    seq_e              st;

    logic [1:0]        region;
    logic [PTR_W-1:0]  idx;
    logic              start_req, launch, busy, last;
    logic              sh_active, word_done, tick;
    logic [WORD_W-1:0] rx_word;

    assign region    = bus_addr[ADDR_W-1:ADDR_W-2];
    assign idx       = bus_addr[PTR_W-1:0];
    assign start_req = bus_we && region == 2'd3 && idx == PTR_W'(3) && bus_wdata[0];
    assign launch    = start_req && st == SQ_IDLE && !done_q;
    assign busy      = (st != SQ_IDLE);
    assign last      = (ptr == end_ptr);
    assign cs_n      = ~cs_q;

    qspi_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst),
        .en(sh_active || st == SQ_GAP),
        .half(half_of(ctrl_q.div)),
        .tick(tick)
    );

    qspi_shift #(.W(WORD_W), .BW(BITS_W)) u_shift (
        .clk(clk), .rst(rst),
        .start(st == SQ_LOAD),
        .tx_word(tx_q[ptr]),
        .nbits(word_bits(cmd_q[ptr], ctrl_q.len)),
        .tick(tick), .miso(miso),
        .sclk(sclk), .mosi(mosi), .active(sh_active),
        .word_done(word_done), .rx_word(rx_word)
    );

    // queue storage
    always_ff @(posedge clk) begin
        if (bus_we && region == 2'd0)
            cmd_q[idx] <= '{hold: bus_wdata[7], use_len: bus_wdata[6], sel: bus_wdata[CS_W-1:0]};
        if (bus_we && region == 2'd1)
            tx_q[idx] <= bus_wdata;
        if (st == SQ_RUN && word_done)
            rx_q[ptr] <= rx_word;
    end

    // control registers and sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            end_ptr <= '0;
            wrap_en <= 1'b0;
            done_q  <= 1'b0;
            cs_q    <= '0;
            ptr     <= '0;
            st      <= SQ_IDLE;
        end else begin
            if (bus_we && region == 2'd3 && idx == PTR_W'(0))
                ctrl_q <= '{len: bus_wdata[8+LEN_W-1:8], div: bus_wdata[DIV_W-1:0]};
            if (bus_we && region == 2'd3 && idx == PTR_W'(1)) begin
                end_ptr <= bus_wdata[PTR_W-1:0];
                wrap_en <= bus_wdata[8];
            end
            if (bus_we && region == 2'd3 && idx == PTR_W'(2) && bus_wdata[0])
                done_q <= 1'b0;

            unique case (st)
                SQ_IDLE: if (launch) begin
                    ptr <= '0;
                    st  <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    cs_q <= cmd_q[ptr].sel;
                    st   <= SQ_RUN;
                end
                SQ_RUN: if (word_done) begin
                    if (last) begin
                        done_q <= 1'b1;
                        cs_q   <= '0;
                        ptr    <= '0;
                        st     <= wrap_en ? SQ_GAP : SQ_IDLE;
                    end else begin
                        ptr <= ptr + PTR_W'(1);
                        if (cmd_q[ptr].hold) st <= SQ_LOAD;
                        else begin
                            cs_q <= '0;
                            st   <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: if (tick) st <= SQ_LOAD;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (region)
            2'd0: begin
                bus_rdata[7]        = cmd_q[idx].hold;
                bus_rdata[6]        = cmd_q[idx].use_len;
                bus_rdata[CS_W-1:0] = cmd_q[idx].sel;
            end
            2'd1: bus_rdata = tx_q[idx];
            2'd2: bus_rdata = rx_q[idx];
            default: begin
                if (idx == PTR_W'(0)) bus_rdata = WORD_W'(ctrl_q);
                if (idx == PTR_W'(1)) begin
                    bus_rdata[8]         = wrap_en;
                    bus_rdata[PTR_W-1:0] = end_ptr;
                end
                if (idx == PTR_W'(2)) bus_rdata[1:0] = {busy, done_q};
            end
        endcase
    end

    // R8: a run only begins while the done flag is clear
    p_start_gate_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(done_q));
    // R5: clocks are produced only with a device selected
    p_cs_during_clock_r5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> (cs_n != '1));
    // R7: the flag is raised only by completion of the last entry
    p_done_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(word_done && last));
endmodule

// File: tb/qspi_master_bench.sv
module qspi_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign miso = ~mosi;  // inverting loopback slave

    qspi_master u_qspi_master (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // line monitor, sampled at falling clock edges
    logic        p_sclk = 1'b0, p_cs = 1'b0, p_mosi = 1'b0;
    int          bits = 0, frames = 0, fbits = 0, hi_run = 0, last_half = 0;
    int          gap_run = 0, last_gap = 0, mode_err = 0;
    logic [63:0] acc = '0, facc = '0;
    logic [3:0]  fmask = '0;

    always @(negedge clk) begin
        logic cs_act;
        cs_act = (cs_n != 4'hF);
        if (!rst) begin
            if (cs_act && !p_cs) begin
                bits = 0; acc = '0; fmask = ~cs_n; last_gap = gap_run;
            end
            if (!cs_act) gap_run++; else gap_run = 0;
            if (sclk && !p_sclk) begin bits++; acc = {acc[62:0], mosi}; end
            if (sclk) hi_run++;
            if (!sclk && p_sclk) begin last_half = hi_run; hi_run = 0; end
            if (sclk && p_sclk && mosi != p_mosi) mode_err++;
            if (!cs_act && p_cs) begin frames++; fbits = bits; facc = acc; end
        end
        p_sclk = sclk; p_cs = cs_act; p_mosi = mosi;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_bit(input int b, input logic v);
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(6'h32, s);
            if (s[b] == v) return;
        end
        check(0, "wait", s, v);
    endtask

    task automatic t_reset;
        logic [15:0] s;
        rd(6'h32, s);
        check(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
        check(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
        check(s[1:0] == 2'b00, "R1 status", s, 0);
    endtask

    task automatic t_single_word;
        logic [15:0] s;
        int f0 = frames;
        wr(6'h30, 16'h0C02);           // len 12, half period 2
        wr(6'h31, 16'h0000);           // last entry 0, no repeat
        wr(6'h00, 16'h0041);           // use_len, select 0
        wr(6'h10, 16'hFABC);
        wr(6'h33, 16'h0001);
        rd(6'h32, s);
        check(s[1] == 1'b1, "R10 busy after start", s, 2);
        wait_bit(0, 1'b1);
        repeat (2) @(negedge clk);
        check(frames - f0 == 1, "R5 one frame", frames - f0, 1);
        check(fbits == 12, "R3 programmed length", fbits, 12);
        check(facc == 64'hABC, "R2 msb first", facc, 64'hABC);
        check(fmask == 4'b0001, "R5 mask", fmask, 1);
        check(last_half == 2, "R4 half period", last_half, 2);
        rd(6'h20, s);
        check(s == 16'h0543, "R2 receive word", s, 16'h0543);
        rd(6'h32, s);
        check(s[1:0] == 2'b01, "R7 done set, R10 idle", s, 1);
    endtask

    task automatic t_start_blocked;
        logic [15:0] s;
        int f0 = frames;
        wr(6'h33, 16'h0001);
        repeat (30) @(negedge clk);
        rd(6'h32, s);
        check(frames == f0 && cs_n == 4'hF, "R8 start ignored", frames - f0, 0);
        check(s[1] == 1'b0, "R8 stays idle", s, 1);
        wr(6'h32, 16'h0000);
        rd(6'h32, s);
        check(s[0] == 1'b1, "R7 write 0 keeps flag", s, 1);
        wr(6'h32, 16'h0001);
        rd(6'h32, s);
        check(s[0] == 1'b0, "R7 write 1 clears", s, 0);
    endtask

    task automatic t_held_frame;
        logic [15:0] s;
        int f0 = frames;
        wr(6'h30, 16'h0003);
        wr(6'h31, 16'h0002);
        for (int i = 0; i < 3; i++) wr(6'(i), 16'h0082);   // hold, 8-bit default, select 1
        wr(6'h10, 16'h0012); wr(6'h11, 16'h0034); wr(6'h12, 16'hFF56);
        wr(6'h33, 16'h0001);
        wait_bit(0, 1'b1);
        repeat (2) @(negedge clk);
        check(frames - f0 == 1, "R5 held select one frame", frames - f0, 1);
        check(fbits == 24, "R3 default length x3", fbits, 24);
        check(facc == 64'h123456, "R6 paired tx order", facc, 64'h123456);
        check(fmask == 4'b0010, "R5 mask", fmask, 2);
        check(cs_n == 4'hF, "R7 release at last entry", cs_n, 4'hF);
        check(last_half == 3, "R4 half period 3", last_half, 3);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] e;
            e = (i == 0) ? 8'hED : (i == 1) ? 8'hCB : 8'hA9;
            rd(6'h20 + 6'(i), s);
            check(s == {8'h00, e}, "R6 receive order", s, e);
        end
        check(mode_err == 0, "R2 mosi stable while high", mode_err, 0);
        wr(6'h32, 16'h0001);
    endtask

    task automatic t_separate;
        logic [15:0] s;
        int f0 = frames;
        wr(6'h30, 16'h0001);           // len 16 (field 0), half period 1
        wr(6'h31, 16'h0001);
        wr(6'h00, 16'h0044);           // no hold, use_len, select 2
        wr(6'h01, 16'h0048);           // no hold, use_len, select 3
        wr(6'h10, 16'h8001); wr(6'h11, 16'h0000);
        wr(6'h33, 16'h0001);
        wait_bit(0, 1'b1);
        repeat (2) @(negedge clk);
        check(frames - f0 == 2, "R5 released between entries", frames - f0, 2);
        check(last_gap >= 1, "R5 gap at least half period", last_gap, 1);
        check(fbits == 16, "R3 length field 0 means 16", fbits, 16);
        check(facc == 64'h0 && fmask == 4'b1000, "R6 zero word keeps mosi low", facc, 0);
        check(last_half == 1, "R4 divider 1", last_half, 1);
        rd(6'h20, s);
        check(s == 16'h7FFE, "R2 receive 16-bit", s, 16'h7FFE);
        rd(6'h21, s);
        check(s == 16'hFFFF, "R6 read-only word", s, 16'hFFFF);
        wr(6'h32, 16'h0001);
    endtask

    task automatic t_repeat;
        logic [15:0] s;
        int f0 = frames;
        wr(6'h31, 16'h0101);           // last entry 1, repeat on
        wr(6'h00, 16'h0001); wr(6'h01, 16'h0001);
        wr(6'h33, 16'h0001);
        wait_bit(0, 1'b1);
        rd(6'h32, s);
        check(s[1] == 1'b1, "R9 still running after pass", s, 3);
        wr(6'h32, 16'h0001);
        wr(6'h31, 16'h0001);           // repeat off
        wait_bit(1, 1'b0);
        repeat (2) @(negedge clk);
        rd(6'h32, s);
        check(frames - f0 >= 4 && (frames - f0) % 2 == 0, "R9 whole passes", frames - f0, 4);
        check(s[0] == 1'b1, "R9 flag on final pass", s, 1);
        wr(6'h32, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_word();
        t_start_blocked();
        t_held_frame();
        t_separate();
        t_repeat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule